// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block gathers the interrupt requests of a small microcontroller and turns them into one request line and one vector address for the CPU. It handles three kinds of request. The first is a high-rank request that only the CPU's X mask bit can hold off. The second is an external pin request. The third is a bank of up to 56 peripheral lines. The pin and peripheral lines are all held off by the CPU's I mask bit. Each source owns a fixed low byte. The X request uses 0xF4, the pin request 0xF2, and peripheral line k uses 0xF0 - 2k. When several sources are pending, the larger low byte wins.

When the CPU strobes its vector fetch, the block registers a 16-bit address. The upper byte comes from a programmable vector base that resets to 0xFF. The lower byte is the winning source's low byte. If nothing unmasked is pending at the strobe, the low byte is 0x80, which is the spurious vector.

The wake-up output is built from the raw request lines with no clock in its path, so it works while clocks are stopped. In stop mode, the X request wakes the device even while it is masked, but it then raises no request to the CPU.

Top module: `int_vec_ctrl`

## Requirements
- R1: After reset the vector output reads 0xFF80 and the vector base holds 0xFF.
- R2: A write strobe loads the base byte. Each later capture puts the base held before that capture's edge into bits 15:8 of the vector.
- R3: An X request with the X mask clear gives low byte 0xF4 and wins over every other source. The I mask has no effect on it.
- R4: The pin request gives low byte 0xF2. It wins over every peripheral line.
- R5: Peripheral line k gives low byte 0xF0 - 2k. Among the pending lines, the lowest index wins.
- R6: With the I mask set, the pin and peripheral lines neither raise the CPU request nor affect the captured vector.
- R7: The CPU request is high exactly when an X request is unmasked, or when the I mask is clear and the pin or any peripheral line is pending.
- R8: A fetch strobe with no unmasked request pending captures low byte 0x80.
- R9: The vector changes only on a clock edge where the fetch strobe is high.
- R10: Outside stop mode, wake-up stays low. In stop mode it is high for an X request whatever the X mask, and for the pin or peripheral lines only when the I mask is clear.
- R11: Wake-up is not held. It falls as soon as the request that raised it is withdrawn.
- R12: An X request with the X mask set raises wake-up in stop mode but leaves the CPU request low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_we | input | 1 | Vector base write strobe |
| base_din | input | 8 | New vector base byte |
| i_mask | input | 1 | CPU I mask bit |
| x_mask | input | 1 | CPU X mask bit |
| stop_mode | input | 1 | Device is in stop mode |
| ack | input | 1 | Vector fetch strobe from the CPU |
| xreq | input | 1 | X-class request |
| irq_req | input | 1 | External pin request |
| src_req | input | N_SRC | Peripheral requests, index 0 highest |
| int_req | output | 1 | Request to the CPU |
| vec_addr | output | 16 | Registered vector address |
| wake | output | 1 | Unclocked wake-up |

## Verification
The bench targets a request that is withdrawn just before the fetch. A design that latched the request would return a real handler's vector here instead of 0x80. It also checks that a masked X request still wakes the device in stop mode but raises no CPU request. Swapping these two conditions would either call a handler that must not run or leave the device asleep. Random patterns with several lines active at once test the peripheral priority order, where an inverted encoder would pick the highest index. Held strobes test that the vector stays stable until the next fetch.

// File: rtl/int_vec_ctrl.sv
module int_vec_ctrl #(
  parameter int N_SRC = 56
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_we,
  input  logic [7:0]       base_din,
  input  logic             i_mask,
  input  logic             x_mask,
  input  logic             stop_mode,
  input  logic             ack,
  input  logic             xreq,
  input  logic             irq_req,
  input  logic [N_SRC-1:0] src_req,
  output logic             int_req,
  output logic [15:0]      vec_addr,
  output logic             wake
);
  localparam logic [7:0] X_LOW   = 8'hF4;
  localparam logic [7:0] IRQ_LOW = 8'hF2;
  localparam int         SRC_TOP = 'hF0;
  localparam logic [7:0] SPUR    = 8'h80;

  logic [7:0] base_q;
  logic [7:0] pick;
  logic       x_live, i_any;

  assign x_live  = xreq & ~x_mask;
  assign i_any   = irq_req | (|src_req);
  assign int_req = x_live | (~i_mask & i_any);
  assign wake    = stop_mode & (xreq | (~i_mask & i_any));

  always_comb begin
    pick = SPUR;
    if (!i_mask) begin
      for (int k = N_SRC - 1; k >= 0; k--)
        if (src_req[k]) pick = 8'(SRC_TOP - 2 * k);
      if (irq_req) pick = IRQ_LOW;
    end
    if (x_live) pick = X_LOW;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      base_q   <= 8'hFF;
      vec_addr <= {8'hFF, SPUR};
    end else begin
      if (base_we) base_q <= base_din;
      if (ack) vec_addr <= {base_q, pick};
    end
endmodule

module int_vec_ctrl_chk #(
  parameter int N_SRC = 56
) (
  input logic             clk,
  input logic             rst_n,
  input logic             i_mask,
  input logic             x_mask,
  input logic             stop_mode,
  input logic             ack,
  input logic             xreq,
  input logic             irq_req,
  input logic [N_SRC-1:0] src_req,
  input logic             int_req,
  input logic [15:0]      vec_addr,
  input logic             wake
);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> $stable(vec_addr));
  p_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !int_req) |=> vec_addr[7:0] == 8'h80);
  p_xwin_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && xreq && !x_mask) |=> vec_addr[7:0] == 8'hF4);
  p_irqwin_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_req && !i_mask && !(xreq && !x_mask)) |=> vec_addr[7:0] == 8'hF2);
  p_imask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (i_mask && (x_mask || !xreq)) |-> !int_req);
  p_nowake_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_mode |-> !wake);
  p_xwake_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_mode && xreq && x_mask && i_mask) |-> (wake && !int_req));
  p_nolatch_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!xreq && !irq_req && src_req == '0) |-> (!wake && !int_req));
endmodule

bind int_vec_ctrl int_vec_ctrl_chk #(.N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .i_mask(i_mask), .x_mask(x_mask),
  .stop_mode(stop_mode), .ack(ack), .xreq(xreq), .irq_req(irq_req),
  .src_req(src_req), .int_req(int_req), .vec_addr(vec_addr), .wake(wake));

// File: tb/int_vec_ctrl_tb.sv
module int_vec_ctrl_tb;
  localparam int N = 56;
  localparam time CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic base_we = 0, i_mask = 1, x_mask = 1, stop_mode = 0, ack = 0;
  logic xreq = 0, irq_req = 0;
  logic [7:0] base_din = 0;
  logic [N-1:0] src_req = '0;
  logic int_req, wake;
  logic [15:0] vec_addr;
  int n_run = 0, n_fail = 0;
  logic [7:0] base_m = 8'hFF;
  logic [15:0] vec_m = 16'hFF80;

  always #(CLK_P/2) clk = ~clk;

  int_vec_ctrl #(.N_SRC(N)) u_dut (.*);

  function automatic logic [7:0] exp_low(logic x, logic xm, logic im, logic ir, logic [N-1:0] s);
    if (x && !xm) return 8'hF4;
    if (!im) begin
      if (ir) return 8'hF2;
      for (int k = 0; k < N; k++) if (s[k]) return 8'(8'hF0 - 2 * k);
    end
    return 8'h80;
  endfunction

  function automatic logic exp_req(logic x, logic xm, logic im, logic ir, logic [N-1:0] s);
    return (x && !xm) || (!im && (ir || s != '0));
  endfunction

  function automatic logic exp_wake(logic st, logic x, logic im, logic ir, logic [N-1:0] s);
    return st && (x || (!im && (ir || s != '0)));
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // inputs already driven after a negedge; check comb, step one edge, check vector
  task automatic step(string tag);
    #1;
    chk({tag, " R7 int_req"}, 16'(int_req), 16'(exp_req(xreq, x_mask, i_mask, irq_req, src_req)));
    chk({tag, " R10 wake"}, 16'(wake), 16'(exp_wake(stop_mode, xreq, i_mask, irq_req, src_req)));
    if (ack) vec_m = {base_m, exp_low(xreq, x_mask, i_mask, irq_req, src_req)};
    if (base_we) base_m = base_din;
    @(negedge clk);
    chk({tag, " R5/R9 vector"}, vec_addr, vec_m);
  endtask

  initial begin
    fork
      begin
        void'($urandom(32'd4242));
        #(CLK_P * 3);
        @(negedge clk);
        chk("R1 reset vector", vec_addr, 16'hFF80);
        rst_n = 1;
        ack = 1; step("R1 default base");
        ack = 0; base_we = 1; base_din = 8'h3C; step("R2 write");
        base_we = 0; i_mask = 0; src_req[5] = 1; src_req[20] = 1; ack = 1;
        step("R5 two lines");
        chk("R2 base in vector", {8'h00, vec_addr[15:8]}, 16'h003C);
        chk("R5 line5", {8'h00, vec_addr[7:0]}, 16'h00E6);
        src_req = '0; src_req[N-1] = 1; step("R5 last line");
        chk("R5 line55 0x82", {8'h00, vec_addr[7:0]}, 16'h0082);
        irq_req = 1; step("R4 irq over lines");
        i_mask = 1; xreq = 1; x_mask = 0; step("R3 X over masked");
        chk("R3 0xF4", {8'h00, vec_addr[7:0]}, 16'h00F4);
        xreq = 0; step("R6 masked gives spurious");
        i_mask = 0; irq_req = 0; src_req = '0; step("R8 withdrawn -> spurious");
        chk("R8 0x80", {8'h00, vec_addr[7:0]}, 16'h0080);
        ack = 0; src_req[3] = 1; step("R9 no strobe hold");
        src_req = '0;
        stop_mode = 1; x_mask = 1; i_mask = 1; xreq = 1; step("R12 masked X wake");
        chk("R12 no cpu request", 16'(int_req), 16'h0);
        chk("R12 wake high", 16'(wake), 16'h1);
        xreq = 0; #1;
        chk("R11 wake drops", 16'(wake), 16'h0);
        @(negedge clk);
        irq_req = 1; step("R10 I masked no wake");
        i_mask = 0; step("R10 I open wake");
        irq_req = 0;
        for (int i = 0; i < 400; i++) begin
          logic [63:0] r;
          r = {$urandom, $urandom};
          src_req = ($urandom % 3 == 0) ? '0 : N'(r & {$urandom, $urandom} & {$urandom, $urandom});
          xreq = ($urandom % 4) == 0;
          irq_req = ($urandom % 5) == 0;
          i_mask = $urandom % 2;
          x_mask = $urandom % 2;
          stop_mode = $urandom % 2;
          ack = ($urandom % 4) != 0;
          base_we = ($urandom % 8) == 0;
          base_din = 8'($urandom);
          step("rnd");
        end
      end
      begin
        #(CLK_P * 20000);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule